// File: doc/BRIEF.md
# Memory-Bound Register Pair File

This block is the architectural register store of a small CPU core where memory is reached through paired registers rather than load and store operations. It holds sixteen word-wide registers: a program counter, five general registers, five pointer registers and five window registers. Pointer n is bound to window n. Writing a pointer schedules a bus read, and the returned word lands in the bound window. Writing a window sends the new value straight to memory at the bound pointer's address. A core that reads a window, computes, and writes the result back to the same window therefore performs a read-modify-write of that memory word.

A pointer that holds all ones parks its pair. A parked pair makes no bus traffic, and its window behaves as an extra scratch register. Writing any other value to the pointer returns the pair to service. Window refills are handled by a two-state fill controller. In `FS_IDLE` it picks the lowest-numbered pair with a pending refill and issues the read when the write port is not using the bus; this is the `issue` transition to `FS_WAIT`. In `FS_WAIT` it waits for the returned data; this is the `return` transition back to `FS_IDLE`. The `rdy` output tells the core when a window it reads is still waiting for memory. General and pointer registers can be stepped up or down by one word after use.

The register index map is fixed. Index 0 is the program counter, indices 1 to 5 are general registers G1 to G5, indices 6 to 10 are pointers P1 to P5, and indices 11 to 15 are windows W1 to W5. The word width is DW bits (16 by default), and a word step is DW/8 bytes.

Top module: `memreg_file`

## Requirements
- R1: After reset the program counter, general and window registers read 0, every pointer reads all ones, `rdy` is 1, and `mem_rd` and `mem_wr` are 0.
- R2: A write to a general register (index 1..5) is read back unchanged on either read port and causes no bus traffic.
- R3: Writing a value other than all ones to pointer n (index 5+n) makes window n (index 10+n) hold the memory word at that address with its low log2(DW/8) bits cleared. The data arrives unshifted, and the pointer itself keeps the value as written, odd bits included.
- R4: While a read port selects a window whose refill is pending or in flight, `rdy` is 0. It is 0 in the very cycle after the pointer write and returns to 1 once the data is loaded.
- R5: A write to window n with an unparked pointer drives `mem_wr`=1, `mem_addr`=aligned pointer value and `mem_wdata`=write data in that same cycle, and updates the window. Reading a window and writing it back updates that memory word.
- R6: With pointer n all ones, window writes update only the register, no `mem_wr` or `mem_rd` is issued for the pair, and the window keeps its value.
- R7: Writing a valid address into a parked pointer makes the pair refill its window from that address.
- R8: A program-counter write stores the data with bit 0 cleared. `pc_inc` adds 2, or 4 when `pc_long`=1. If a write and `pc_inc` occur in the same cycle, the write wins.
- R9: `post_en` steps the register at `post_idx` by DW/8 after the current cycle (down when `post_dec`=1). It applies only to general and pointer registers, a stepped pointer refills its window, and a write port hit on the same index in the same cycle takes priority.
- R10: Two pairs that point at the same word are not kept coherent: a window write through one pair leaves the other pair's window unchanged.
- R11: A window write that lands while its refill is pending, or in the cycle its read data returns, keeps the written value. The stale memory data is discarded.
- R12: `mem_rd` and `mem_wr` are never both 1. A window write takes the bus, and a pending refill waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | DW | Read port B data |
| rdy | output | 1 | Both read ports return settled data |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register index |
| wr_data | input | DW | Write port data |
| post_en | input | 1 | Step request for a general or pointer register |
| post_idx | input | 4 | Index of the register to step |
| post_dec | input | 1 | 1 steps down, 0 steps up |
| pc_inc | input | 1 | Advance the program counter |
| pc_long | input | 1 | Advance by 4 instead of 2 |
| mem_rd | output | 1 | Bus read request |
| mem_wr | output | 1 | Bus write strobe |
| mem_addr | output | DW | Word-aligned bus address |
| mem_wdata | output | DW | Bus write data |
| mem_rdata | input | DW | Bus read data |
| mem_rvalid | input | 1 | Read data valid, one per request |

## Verification
A window write can share a cycle with a refill of the same pair, either while the refill is still pending or in the cycle its read data comes back. The bench provokes the first case with back-to-back pointer and window writes. It provokes the second by inserting one idle cycle so that the window write meets `mem_rvalid`. Each case is judged by sampling `mem_rd` and `mem_wr` during the write cycle, then reading the window and the bench memory word. Both must hold the written value and not the stale memory data.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
    localparam int NPAIR = 5;
    localparam int NREG  = 16;
    localparam int IDXW  = 4;
    localparam int PAIRW = 3;

    localparam logic [IDXW-1:0] IDX_PC   = 4'd0;
    localparam logic [IDXW-1:0] IDX_GEN0 = 4'd1;
    localparam logic [IDXW-1:0] IDX_PTR0 = 4'd6;
    localparam logic [IDXW-1:0] IDX_WIN0 = 4'd11;

    typedef enum logic {
        FS_IDLE,
        FS_WAIT
    } fill_state_t;

    function automatic logic is_gen(input logic [IDXW-1:0] i);
        return (i >= IDX_GEN0) && (i < IDX_PTR0);
    endfunction

    function automatic logic is_ptr(input logic [IDXW-1:0] i);
        return (i >= IDX_PTR0) && (i < IDX_WIN0);
    endfunction

    function automatic logic is_win(input logic [IDXW-1:0] i);
        return i >= IDX_WIN0;
    endfunction
endpackage

// File: rtl/rfp_fill_ctrl.sv
module rfp_fill_ctrl
    import rfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPAIR-1:0] pend_set,
    input  logic [NPAIR-1:0] pend_clr,
    input  logic [NPAIR-1:0] touch,
    input  logic             bus_taken,
    input  logic             mem_rvalid,
    output logic             issue,
    output logic [PAIRW-1:0] sel_pair,
    output logic             fill_en,
    output logic [NPAIR-1:0] busy
);
    fill_state_t      state, state_n;
    logic [NPAIR-1:0] pend;
    logic [NPAIR-1:0] first_oh;
    logic [PAIRW-1:0] first;
    logic [PAIRW-1:0] wait_pair;
    logic             fresh;
    logic             wait_touched;

    // lowest-numbered pending pair wins
    always_comb begin
        first    = '0;
        first_oh = '0;
        for (int p = NPAIR - 1; p >= 0; p--) begin
            if (pend[p]) begin
                first    = PAIRW'(p);
                first_oh = NPAIR'(1) << p;
            end
        end
    end

    always_comb begin
        wait_touched = 1'b0;
        for (int p = 0; p < NPAIR; p++) begin
            if (wait_pair == PAIRW'(p) && touch[p]) wait_touched = 1'b1;
        end
    end

    // output process
    always_comb begin
        issue    = 1'b0;
        fill_en  = 1'b0;
        sel_pair = first;
        busy     = pend;
        state_n  = state;
        unique case (state)
            FS_IDLE: begin
                issue = (|pend) && !bus_taken;
                if (issue) state_n = FS_WAIT;
            end
            FS_WAIT: begin
                sel_pair = wait_pair;
                fill_en  = mem_rvalid && fresh && !wait_touched;
                if (fresh) busy = pend | (NPAIR'(1) << wait_pair);
                if (mem_rvalid) state_n = FS_IDLE;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FS_IDLE;
            pend      <= '0;
            wait_pair <= '0;
            fresh     <= 1'b0;
        end else begin
            state <= state_n;
            pend  <= (pend & ~pend_clr & ~(issue ? first_oh : '0)) | pend_set;
            if (issue) begin
                wait_pair <= first;
                fresh     <= ~|(touch & first_oh);
            end else if (wait_touched) begin
                fresh <= 1'b0;
            end
        end
    end

    // R12: one refill in flight, no new request while waiting
    p_no_issue_in_wait_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_WAIT) |-> !issue);
    // R11: data returning for a touched pair is never loaded
    p_stale_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FS_WAIT && wait_touched) |-> !fill_en);
endmodule

// File: rtl/rfp_regs.sv
module rfp_regs
    import rfp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDXW-1:0]     wr_idx,
    input  logic [DW-1:0]       wr_data,
    input  logic                post_we,
    input  logic [IDXW-1:0]     post_idx,
    input  logic [DW-1:0]       post_val,
    input  logic                pc_inc,
    input  logic                pc_long,
    input  logic                fill_en,
    input  logic [PAIRW-1:0]    fill_pair,
    input  logic [DW-1:0]       fill_data,
    input  logic [IDXW-1:0]     rd_a_idx,
    input  logic [IDXW-1:0]     rd_b_idx,
    output logic [DW-1:0]       rd_a_data,
    output logic [DW-1:0]       rd_b_data,
    output logic [DW-1:0]       post_cur,
    output logic [NPAIR*DW-1:0] ptr_flat
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        localparam logic [IDXW-1:0] MY = IDXW'(g);
        logic [DW-1:0] q;
        logic          wr_hit;
        assign wr_hit  = wr_en && (wr_idx == MY);
        assign regs[g] = q;

        if (g == 0) begin : g_pc
            always_ff @(posedge clk) begin
                if (!rst_n)       q <= '0;
                else if (wr_hit)  q <= {wr_data[DW-1:1], 1'b0};
                else if (pc_inc)  q <= q + (pc_long ? DW'(4) : DW'(2));
            end
        end else if (g < int'(IDX_WIN0)) begin : g_step
            localparam logic [DW-1:0] RST = (g >= int'(IDX_PTR0)) ? '1 : '0;
            always_ff @(posedge clk) begin
                if (!rst_n)                              q <= RST;
                else if (wr_hit)                         q <= wr_data;
                else if (post_we && post_idx == MY)      q <= post_val;
            end
        end else begin : g_win
            localparam logic [PAIRW-1:0] PR = PAIRW'(g - int'(IDX_WIN0));
            always_ff @(posedge clk) begin
                if (!rst_n)                              q <= '0;
                else if (wr_hit)                         q <= wr_data;
                else if (fill_en && fill_pair == PR)     q <= fill_data;
            end
        end
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_ptr_out
        assign ptr_flat[p*DW +: DW] = regs[int'(IDX_PTR0) + p];
    end

    assign rd_a_data = regs[rd_a_idx];
    assign rd_b_data = regs[rd_b_idx];
    assign post_cur  = regs[post_idx];

    // R8: program counter stays even
    p_pc_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0][0] == 1'b0);
    // R8: advance adds the selected step when no write competes
    p_pc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_inc && !(wr_en && wr_idx == IDX_PC)) |=>
        regs[0] == $past(regs[0]) + ($past(pc_long) ? DW'(4) : DW'(2)));
endmodule

// File: rtl/memreg_file.sv
module memreg_file
    import rfp_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      rd_a_idx,
    output logic [DW-1:0]   rd_a_data,
    input  logic [3:0]      rd_b_idx,
    output logic [DW-1:0]   rd_b_data,
    output logic            rdy,
    input  logic            wr_en,
    input  logic [3:0]      wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic            post_en,
    input  logic [3:0]      post_idx,
    input  logic            post_dec,
    input  logic            pc_inc,
    input  logic            pc_long,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_rvalid
);
    localparam int            STEP  = DW / 8;
    localparam logic [DW-1:0] AMASK = ~DW'(STEP - 1);

    logic [NPAIR*DW-1:0] ptr_flat;
    logic [DW-1:0]       ptr_of [NPAIR];
    logic [NPAIR-1:0]    wr_p, wr_w, post_p, rd_a_w, rd_b_w;
    logic [NPAIR-1:0]    pend_set, pend_clr, touch, busy;
    logic [DW-1:0]       post_cur, post_val, w_addr, r_addr;
    logic [PAIRW-1:0]    sel_pair;
    logic                post_hit, wr_park, post_park, fill_en, issue;

    assign post_hit  = post_en && (is_gen(post_idx) || is_ptr(post_idx))
                       && !(wr_en && wr_idx == post_idx);
    assign post_val  = post_dec ? post_cur - DW'(STEP) : post_cur + DW'(STEP);
    assign wr_park   = &wr_data;
    assign post_park = &post_val;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign ptr_of[p] = ptr_flat[p*DW +: DW];
        assign wr_p[p]   = wr_en && wr_idx == IDX_PTR0 + IDXW'(p);
        assign wr_w[p]   = wr_en && wr_idx == IDX_WIN0 + IDXW'(p);
        assign post_p[p] = post_hit && post_idx == IDX_PTR0 + IDXW'(p);
        assign rd_a_w[p] = rd_a_idx == IDX_WIN0 + IDXW'(p);
        assign rd_b_w[p] = rd_b_idx == IDX_WIN0 + IDXW'(p);
    end

    assign pend_set = (wr_p & {NPAIR{!wr_park}}) | (post_p & {NPAIR{!post_park}});
    assign pend_clr = wr_w | (wr_p & {NPAIR{wr_park}}) | (post_p & {NPAIR{post_park}});
    assign touch    = wr_p | wr_w | post_p;

    always_comb begin
        w_addr = '1;
        r_addr = '1;
        for (int p = 0; p < NPAIR; p++) begin
            if (wr_w[p]) w_addr = ptr_of[p];
            if (sel_pair == PAIRW'(p)) r_addr = ptr_of[p];
        end
    end

    assign mem_wr    = (|wr_w) && !(&w_addr);
    assign mem_rd    = issue;
    assign mem_addr  = (mem_wr ? w_addr : r_addr) & AMASK;
    assign mem_wdata = wr_data;
    assign rdy       = !(|(rd_a_w & busy)) && !(|(rd_b_w & busy));

    rfp_fill_ctrl u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_set   (pend_set),
        .pend_clr   (pend_clr),
        .touch      (touch),
        .bus_taken  (mem_wr),
        .mem_rvalid (mem_rvalid),
        .issue      (issue),
        .sel_pair   (sel_pair),
        .fill_en    (fill_en),
        .busy       (busy)
    );

    rfp_regs #(.DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .post_we    (post_hit),
        .post_idx   (post_idx),
        .post_val   (post_val),
        .pc_inc     (pc_inc),
        .pc_long    (pc_long),
        .fill_en    (fill_en),
        .fill_pair  (sel_pair),
        .fill_data  (mem_rdata),
        .rd_a_idx   (rd_a_idx),
        .rd_b_idx   (rd_b_idx),
        .rd_a_data  (rd_a_data),
        .rd_b_data  (rd_b_data),
        .post_cur   (post_cur),
        .ptr_flat   (ptr_flat)
    );

    // R12: a single bus, one direction per cycle
    p_bus_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R6: a refill is never issued for a parked pair
    p_no_parked_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !(&r_addr));
endmodule

// File: tb/tb_memreg_file.sv
module tb_memreg_file;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, post_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0, mem_addr, mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          rdy, wr_en = 0, post_en = 0, post_dec = 0, pc_inc = 0, pc_long = 0;
    logic          mem_rd, mem_wr, mem_rvalid = 0;

    int total = 0, bad = 0, cyc = 0, nwr = 0, nrd = 0, nboth = 0;
    logic [DW-1:0] mem [64];

    always #2 clk = ~clk;

    memreg_file #(.DW(DW)) dut (.*);

    // bench memory: one-cycle read latency
    always @(posedge clk) begin
        mem_rvalid <= mem_rd;
        if (mem_rd) mem_rdata <= mem[mem_addr[6:1]];
        if (mem_wr) mem[mem_addr[6:1]] <= mem_wdata;
        if (rst_n) begin
            if (mem_wr) nwr++;
            if (mem_rd) nrd++;
            if (mem_rd && mem_wr) nboth++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            bad++;
            $display("FAIL watchdog act=%0d exp=<50000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [DW-1:0] init_word(input int i);
        return 16'h5A00 | DW'(i);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] idx, input logic [DW-1:0] d);
        wr_en = 1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic do_post(input logic [3:0] idx, input logic dec);
        post_en = 1; post_idx = idx; post_dec = dec;
        @(negedge clk);
        post_en = 0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [DW-1:0] d);
        int n = 0;
        rd_a_idx = idx;
        #1;
        while (!rdy && n < 40) begin
            @(negedge clk); #1; n++;
        end
        if (!rdy) chk("R4 rdy timeout", {15'd0, rdy}, 16'd1);
        d = rd_a_data;
    endtask

    // write index, write data, read index, expected read value
    localparam logic [39:0] VEC [8] = '{
        40'h1_1234_1_1234,   // R2 general register
        40'h5_BEEF_5_BEEF,   // R2
        40'h6_0010_B_5A08,   // R3 refill of W1 from word 8
        40'h7_0013_C_5A09,   // R3 odd address, word 9 unshifted
        40'h8_0013_8_0013,   // R3 pointer keeps raw value
        40'hB_5555_B_5555,   // R5 window write
        40'h0_0101_0_0100,   // R8 bit 0 cleared
        40'hA_FFFF_A_FFFF    // R6 park P5
    };

    initial begin
        logic [DW-1:0] v;
        int sw, sr;
        for (int i = 0; i < 64; i++) mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(4'd0, v);  chk("R1 pc", v, 16'h0000);
        rd(4'd1, v);  chk("R1 g1", v, 16'h0000);
        rd(4'd6, v);  chk("R1 p1", v, 16'hFFFF);
        rd(4'd11, v); chk("R1 w1", v, 16'h0000);
        chk("R1 rdy/rd/wr", {13'd0, rdy, mem_rd, mem_wr}, 16'h0004);

        foreach (VEC[k]) begin
            @(negedge clk);
            do_write(VEC[k][39:36], VEC[k][35:20]);
            rd(VEC[k][19:16], v);
            chk($sformatf("R2/R3/R5/R6/R8 vec%0d", k), v, VEC[k][15:0]);
        end
        rd_b_idx = 4'd5; #1;
        chk("R2 port b", rd_b_data, 16'hBEEF);
        chk("R5 mem word8", mem[8], 16'h5555);

        // R4 stall right after pointer write
        @(negedge clk);
        do_write(4'd9, 16'h0020);
        rd_a_idx = 4'd14; #1;
        chk("R4 rdy low", {15'd0, rdy}, 16'd0);
        rd(4'd14, v); chk("R4 w4 data", v, 16'h5A10);

        // R6 parked pair: no traffic
        @(negedge clk);
        sw = nwr; sr = nrd;
        do_write(4'd15, 16'h7777);
        repeat (3) @(negedge clk);
        chk("R6 no mem_wr", 16'(nwr - sw), 16'd0);
        chk("R6 no mem_rd", 16'(nrd - sr), 16'd0);
        rd(4'd15, v); chk("R6 w5 kept", v, 16'h7777);

        // R7 unpark
        @(negedge clk);
        do_write(4'd10, 16'h0006);
        rd(4'd15, v); chk("R7 w5 refilled", v, 16'h5A03);

        // R5 write cycle at the ports
        @(negedge clk);
        wr_en = 1; wr_idx = 4'd12; wr_data = 16'hABCD; #1;
        chk("R5 mem_wr", {15'd0, mem_wr}, 16'd1);
        chk("R5 mem_addr", mem_addr, 16'h0012);
        chk("R5 mem_wdata", mem_wdata, 16'hABCD);
        @(negedge clk); wr_en = 0;
        chk("R5 mem word9", mem[9], 16'hABCD);

        // R10 aliasing
        do_write(4'd6, 16'h0012);
        rd(4'd11, v); chk("R10 w1 sees word9", v, 16'hABCD);
        @(negedge clk);
        do_write(4'd12, 16'h1111);
        rd(4'd11, v); chk("R10 w1 not refreshed", v, 16'hABCD);
        chk("R10 mem word9", mem[9], 16'h1111);

        // R5 read-modify-write through one pair
        rd(4'd12, v);
        @(negedge clk);
        do_write(4'd12, v + 16'd1);
        chk("R5 rmw word9", mem[9], 16'h1112);

        // R8 program counter
        do_write(4'd0, 16'h0100);
        pc_inc = 1; pc_long = 0; @(negedge clk); pc_inc = 0;
        rd(4'd0, v); chk("R8 pc +2", v, 16'h0102);
        @(negedge clk);
        pc_inc = 1; pc_long = 1; @(negedge clk); pc_inc = 0;
        rd(4'd0, v); chk("R8 pc +4", v, 16'h0106);
        @(negedge clk);
        pc_inc = 1; pc_long = 0;
        do_write(4'd0, 16'h0201);
        pc_inc = 0;
        rd(4'd0, v); chk("R8 write wins", v, 16'h0200);

        // R9 post step
        @(negedge clk);
        do_post(4'd1, 1'b0);
        rd(4'd1, v); chk("R9 g1 inc", v, 16'h1236);
        @(negedge clk);
        do_post(4'd1, 1'b1);
        do_post(4'd1, 1'b1);
        rd(4'd1, v); chk("R9 g1 dec", v, 16'h1232);
        @(negedge clk);
        do_post(4'd6, 1'b0);
        rd(4'd6, v);  chk("R9 p1 inc", v, 16'h0014);
        rd(4'd11, v); chk("R9 w1 refill", v, 16'h5A0A);
        @(negedge clk);
        sw = nwr; sr = nrd;
        do_post(4'd0, 1'b0);
        do_post(4'd11, 1'b0);
        repeat (3) @(negedge clk);
        rd(4'd0, v);  chk("R9 pc ignored", v, 16'h0200);
        rd(4'd11, v); chk("R9 w1 ignored", v, 16'h5A0A);
        chk("R9 no traffic", 16'(nwr - sw + nrd - sr), 16'd0);
        @(negedge clk);
        post_en = 1; post_idx = 4'd2; post_dec = 0;
        do_write(4'd2, 16'h0040);
        post_en = 0;
        rd(4'd2, v); chk("R9 write over step", v, 16'h0040);

        // R11/R12 window write while refill pending
        rd(4'd13, v);
        @(negedge clk);
        do_write(4'd8, 16'h0030);
        wr_en = 1; wr_idx = 4'd13; wr_data = 16'h2222; #1;
        chk("R12 bus to write", {14'd0, mem_rd, mem_wr}, 16'd1);
        @(negedge clk); wr_en = 0;
        repeat (4) @(negedge clk);
        rd(4'd13, v); chk("R11 pending dropped", v, 16'h2222);
        chk("R11 mem word24", mem[24], 16'h2222);

        // R11 window write in the data-return cycle
        @(negedge clk);
        do_write(4'd8, 16'h0032);
        @(negedge clk);
        do_write(4'd13, 16'h3333);
        repeat (4) @(negedge clk);
        rd(4'd13, v); chk("R11 return dropped", v, 16'h3333);
        chk("R11 mem word25", mem[25], 16'h3333);

        chk("R12 never both", 16'(nboth), 16'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule